// File: doc/BRIEF.md
# Bus I/O Output Port

This block is an output-port slave on a shared parallel bus. Each clock it looks at the strobe, the address and the bus function code. It accepts a cycle only when the address equals its single port address and the function is an I/O write. On an accepted cycle it copies the data bus into an 8-bit holding register. That register drives a set of external output pins and keeps its value until the next accepted write.

The decode runs in two cascaded stages. In one order, an address comparator enables a one-of-four function decoder. In the other order, the decoded I/O-write line enables the address comparator. A parameter picks the order, and both orders behave the same at the ports. The slave reports completion on a shared acknowledge line. It drives that line high through a tri-state output and leaves it floating whenever it is not selected, so other slaves can share the wire. The port never drives the data bus. Bus request, grant and interrupts are outside this block.

Top module: `bus_out_port`

## Requirements
- R1: The port captures data only when `busAddr` equals `PORT_ADDR` (default 0x10). A write strobe at any other address leaves `portOut` unchanged.
- R2: Function codes are: 0 = memory read, 1 = memory write, 2 = I/O read, 3 = I/O write. Only code 3 causes a capture. Codes 0, 1 and 2 at the port address leave `portOut` unchanged.
- R3: On a rising clock edge where `busStb` is high, the address matches and the code is 3, `portOut` takes `busData`. After that edge it keeps the value through every cycle that is not such a write.
- R4: `busAck` is driven high starting the cycle after the first qualifying edge. It stays high for every cycle in which the strobe stays active with a matching address and code.
- R5: `busAck` is not driven high when the port is not selected. This includes the cycle after the strobe drops, and cycles with a mismatched address or function.
- R6: A synchronous reset (`rst` high at a clock edge) clears `portOut` to 0x00 and releases `busAck`, even while a qualifying strobe is present.
- R7: Writing each walking-one value 0x01, 0x02, 0x04 and so on up to 0x80 in turn to the port shows each value on `portOut` after its write.
- R8: Both decode orders (`ADDR_FIRST` = 1 or 0) give identical `portOut` and `busAck` for the same bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| busStb | input | 1 | Cycle strobe from the bus master |
| busAddr | input | ADDR_W | Address bus |
| busFunc | input | 2 | Function code (0 mem rd, 1 mem wr, 2 I/O rd, 3 I/O wr) |
| busData | input | DATA_W | Data bus, sampled only |
| busAck | inout | 1 | Shared acknowledge, driven high or left floating |
| portOut | output | DATA_W | Held output byte |

## Verification
A decode fault that selects the port wrongly shows up as a corrupted `portOut` on the very next cycle. It also makes `busAck` rise one cycle after the bad strobe. A missed selection shows up as a stale output byte and a missing acknowledge, one cycle after the write. An acknowledge register that is stuck or fails to clear appears on the shared line in the cycle after the strobe drops. A capture register that loses its value shows up at once, because the bench compares the output on every cycle against a model that tracks every bus cycle. The bench also compares both decode orders against each other on every cycle.

// File: rtl/outport_pkg.sv
package outport_pkg;

  // Bus function codes carried on busFunc
  typedef enum logic [1:0] {
    FN_MEM_RD = 2'd0,
    FN_MEM_WR = 2'd1,
    FN_IO_RD  = 2'd2,
    FN_IO_WR  = 2'd3
  } busFunc_e;

  localparam int FUNC_W = 2;
  localparam int FUNC_N = 1 << FUNC_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture busData this edge
    logic ackOn;  // drive acknowledge this cycle
  } portCtl_t;

endpackage

// File: rtl/outport_ctrl.sv
module outport_ctrl
  import outport_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 8'h10,
  parameter bit                ADDR_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [FUNC_W-1:0] busFunc,
  output portCtl_t          ctl
);

  localparam int IOWR_IDX = int'(FN_IO_WR);

  logic              addrHit;
  logic [FUNC_N-1:0] funcLines;
  logic              portSel;
  logic              ackQ;

  generate
    if (ADDR_FIRST) begin : g_addrFirst
      // stage 1: address compare, stage 2: function decoder enabled by it
      always_comb begin
        addrHit   = (busAddr == PORT_ADDR);
        funcLines = '0;
        if (addrHit) funcLines[busFunc] = 1'b1;
      end
      assign portSel = funcLines[IOWR_IDX];
    end else begin : g_funcFirst
      // stage 1: function decoder, stage 2: address compare enabled by I/O write line
      always_comb begin
        funcLines          = '0;
        funcLines[busFunc] = 1'b1;
        addrHit            = funcLines[IOWR_IDX] && (busAddr == PORT_ADDR);
      end
      assign portSel = addrHit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ackQ <= 1'b0;
    else     ackQ <= busStb & portSel;
  end

  assign ctl.load  = busStb & portSel;
  assign ctl.ackOn = ackQ;

  // decode qualifies address (R1) and function (R2)
  assert_addr_match_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.load |-> (busAddr == PORT_ADDR));
  assert_func_iowr_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.load |-> (busFunc == FN_IO_WR));
  // acknowledge follows a capture (R4) and is released after strobe drops (R5)
  assert_ack_start_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> ctl.ackOn);
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (rst)
    !busStb |=> !ctl.ackOn);

endmodule

// File: rtl/outport_dpath.sv
module outport_dpath
  import outport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  portCtl_t          ctl,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] portOut,
  output logic              ackDrv
);

  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst)           holdReg <= '0;
    else if (ctl.load) holdReg <= busData;
  end

  assign portOut = holdReg;
  assign ackDrv  = ctl.ackOn;

  // capture and hold (R3)
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (portOut == $past(busData)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(portOut));
  // reset clears output and acknowledge (R6)
  assert_reset_clear_R6: assert property (@(posedge clk)
    $past(rst) |-> (portOut == '0 && !ackDrv));

endmodule

// File: rtl/bus_out_port.sv
module bus_out_port
  import outport_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 8'h10,
  parameter bit                ADDR_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busFunc,
  input  logic [DATA_W-1:0] busData,
  inout  wire               busAck,
  output logic [DATA_W-1:0] portOut
);

  portCtl_t ctl;
  logic     ackDrv;

  outport_ctrl #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR),
    .ADDR_FIRST(ADDR_FIRST)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .busStb (busStb),
    .busAddr(busAddr),
    .busFunc(busFunc),
    .ctl    (ctl)
  );

  outport_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .busData(busData),
    .portOut(portOut),
    .ackDrv (ackDrv)
  );

  // shared acknowledge: drive high when selected, float otherwise
  assign busAck = ackDrv ? 1'b1 : 1'bz;

endmodule

// File: tb/bus_out_port_test.sv
`timescale 1ns/1ps
module bus_out_port_test;

  localparam logic [7:0] PADDR = 8'h10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busStb = 1'b0;
  logic [7:0] busAddr = '0;
  logic [1:0] busFunc = '0;
  logic [7:0] busData = '0;
  wire        ackMain;
  wire        ackSwap;
  logic [7:0] outMain;
  logic [7:0] outSwap;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] expOut = '0;
  logic       expAck = 1'b0;

  always #2 clk = ~clk;

  bus_out_port #(.ADDR_FIRST(1'b1)) uut (
    .clk(clk), .rst(rst), .busStb(busStb), .busAddr(busAddr),
    .busFunc(busFunc), .busData(busData), .busAck(ackMain), .portOut(outMain)
  );

  bus_out_port #(.ADDR_FIRST(1'b0)) uutSwap (
    .clk(clk), .rst(rst), .busStb(busStb), .busAddr(busAddr),
    .busFunc(busFunc), .busData(busData), .busAck(ackSwap), .portOut(outSwap)
  );

  function automatic bit qualifies(input logic s, input logic [7:0] a, input logic [1:0] f);
    return s && (a == PADDR) && (f == 2'd3);
  endfunction

  task automatic checkNow(input string tag);
    total++;
    if (outMain !== expOut) begin
      bad++;
      $display("FAIL %s portOut actual=%02h expected=%02h", tag, outMain, expOut);
    end
    total++;
    if ((ackMain === 1'b1) != expAck) begin
      bad++;
      $display("FAIL %s busAck actual=%b expected=%b", tag, ackMain, expAck);
    end
    total++;
    if (outSwap !== outMain || ((ackSwap === 1'b1) != (ackMain === 1'b1))) begin
      bad++;
      $display("FAIL R8 swapped order actual=%02h/%b expected=%02h/%b",
               outSwap, ackSwap, outMain, ackMain);
    end
  endtask

  // drive at negedge, model the edge, check at next negedge
  task automatic step(input logic r, input logic s, input logic [7:0] a,
                      input logic [1:0] f, input logic [7:0] d, input string tag);
    rst = r; busStb = s; busAddr = a; busFunc = f; busData = d;
    @(posedge clk);
    if (r) begin
      expOut = 8'h00;
      expAck = 1'b0;
    end else begin
      if (qualifies(s, a, f)) expOut = d;
      expAck = qualifies(s, a, f);
    end
    @(negedge clk);
    checkNow(tag);
  endtask

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd2024);
    @(negedge clk);
    step(1, 0, 8'h00, 2'd0, 8'h00, "R6");
    step(1, 1, PADDR, 2'd3, 8'hAA, "R6");   // reset wins over a qualifying write

    // R7: walking ones
    for (int i = 0; i < 8; i++) begin
      step(0, 1, PADDR, 2'd3, 8'(1 << i), "R7");
      step(0, 0, PADDR, 2'd3, 8'hFF, "R7");
    end

    // R1: other addresses ignored
    step(0, 1, 8'h11, 2'd3, 8'h5A, "R1");
    step(0, 1, 8'h00, 2'd3, 8'h5A, "R1");
    step(0, 1, 8'h90, 2'd3, 8'h5A, "R1");
    // R2: other functions at the port address ignored
    step(0, 1, PADDR, 2'd0, 8'h33, "R2");
    step(0, 1, PADDR, 2'd1, 8'h33, "R2");
    step(0, 1, PADDR, 2'd2, 8'h33, "R2");
    // R4: acknowledge held while the strobe is held
    step(0, 1, PADDR, 2'd3, 8'hC3, "R4");
    step(0, 1, PADDR, 2'd3, 8'hC3, "R4");
    step(0, 1, PADDR, 2'd3, 8'hC3, "R4");
    // R5: released after the strobe drops
    step(0, 0, PADDR, 2'd3, 8'hC3, "R5");
    step(0, 0, 8'h00, 2'd0, 8'h00, "R5");
    // R3: data changes with no strobe leave the output held
    step(0, 0, PADDR, 2'd3, 8'h7E, "R3");
    // R6: mid-run reset while acknowledged
    step(0, 1, PADDR, 2'd3, 8'h99, "R6");
    step(1, 1, PADDR, 2'd3, 8'h99, "R6");
    step(0, 0, 8'h00, 2'd0, 8'h00, "R6");

    // constrained random mix, checked against the model (R3)
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int sel;
      sel = int'($urandom % 8);
      case (sel)
        0:       a = 8'($urandom);
        1:       a = PADDR ^ 8'(1 << ($urandom % 8));
        default: a = PADDR;
      endcase
      step(($urandom % 50) == 0, ($urandom % 4) != 0, a,
           2'($urandom), 8'($urandom), "R3");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule